// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and calendar date for a register-mapped real-time clock. It holds seven fields, all in packed BCD: seconds, minutes, hours, weekday, day of month, month and a two-digit year. The year stands for 2000 through 2099. A parameterised prescaler divides an oscillator-rate strobe down to one advance per second. The carry then runs through the whole calendar, with month lengths and leap Februaries handled.

The hour byte sets its own format. If its mode bit is clear, the hour counts 00–23. If the mode bit is set, the hour counts 1–12 and a second bit marks PM. A host port loads any field and reads any register back without delay. A control byte holds two bits. One stops the count; it comes up set at reset, which flags the time as not yet valid. The other write-protects the time fields.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset, the control register reads 0x80 (stopped). Seconds, minutes and hours read 0x00, the weekday reads 0x01, date and month read 0x01, and the year reads 0x00.
- R2: While control bit 7 is clear, seconds advance by one for every TICKS_PER_SEC oscillator strobes. Seconds and minutes count BCD 00–59. Each wraps to 00 and carries into the next field.
- R3: While control bit 7 is set, strobes are ignored and every time field holds its value.
- R4: With hour bit 6 clear, the hour counts BCD 00–23. The step from 23 to 00 carries into the day.
- R5: With hour bit 6 set, bit 5 is PM and bits 4:0 hold a BCD hour of 1–12. 11 AM steps to 12 PM (0x72), 12 steps to 1 and keeps the PM bit, and 11 PM (0x71) steps to 12 AM (0x52) and carries into the day.
- R6: On a day carry the weekday counts 1 to 7 and then wraps to 1.
- R7: On a day carry, the date wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days, and 02 has 28 days. In a year divisible by 4, month 02 has 29 days. The other months have 31.
- R8: A date wrap advances the month 01–12. Month 12 wraps to 01 and advances the year, and the year wraps 99 to 00.
- R9: While control bit 6 is set, host writes to addresses 0–6 are ignored. The control register stays writable.
- R10: An accepted write to a time field restarts the prescaler. The next second then comes after TICKS_PER_SEC more strobes.
- R11: Address 0 is seconds, then minutes, hours, weekday, date, month and year at 6, with control at 7. Each reads back what was written, with unused high bits read as zero: weekday keeps bits 2:0, month bits 4:0, date bits 5:0, and seconds, minutes and hours bits 6:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | One-cycle oscillator strobe |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | ADDR_W | Host read address |
| rd_data_o | output | 8 | Register value at rd_addr_i, combinational |

## Verification
A long run of seconds from midnight in 24-hour format exposes any fault in the BCD digit carry and in the minute/hour chaining. Every hour of both formats is then loaded one second before its rollover. This separates the 24-hour wrap from the three special 12-hour steps: the PM toggle at 11, the 12→1 step and the midnight day carry. Month ends are swept with each month loaded on its last day, and the years 00–99 are swept both at 28 February and at 31 December. Together these separate 30- and 31-day months and leap from common years, and show the year wrap. Short strobe counts around host writes and around the control bits show the prescaler restart, the stop bit and the write protection.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int unsigned NUM_REGS   = 8;
   localparam int unsigned CTRL_ADDR  = 7;
   localparam int unsigned STOP_BIT   = 7;
   localparam int unsigned WPROT_BIT  = 6;
   localparam int unsigned H12_BIT    = 6;
   localparam int unsigned PM_BIT     = 5;

   typedef enum logic [2:0] {
      F_SEC  = 3'd0,
      F_MIN  = 3'd1,
      F_HOUR = 3'd2,
      F_WDAY = 3'd3,
      F_DATE = 3'd4,
      F_MON  = 3'd5,
      F_YEAR = 3'd6
   } field_e;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
      logic [6:0] ybin;
      ybin = bcd_to_bin(yr);
      case (mon)
         8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   input  logic run_i,
   input  logic clear_i,
   output logic sec_pulse_o
);
   generate
      if (TICKS_PER_SEC < 1) begin : g_bad
         $error("TICKS_PER_SEC must be at least 1");
      end
      if (TICKS_PER_SEC == 1) begin : g_direct
         assign sec_pulse_o = strobe_i && run_i && !clear_i;
      end else begin : g_count
         localparam int unsigned CW = $clog2(TICKS_PER_SEC);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (clear_i)            cnt_q <= '0;
            else if (run_i && strobe_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end

         assign sec_pulse_o = strobe_i && run_i && !clear_i && (cnt_q == LAST);

         assert_clear_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i |=> (cnt_q == '0));
         assert_hold_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_i && !clear_i) |=> $stable(cnt_q));
      end
   endgenerate
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
   parameter logic [7:0] LO = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [7:0] load_val_i,
   input  logic       inc_i,
   input  logic [7:0] limit_i,
   output logic [7:0] q_o,
   output logic       wrap_o
);
   import cal_pkg::*;
   logic [7:0] q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_q <= LO;
      else if (load_i) q_q <= load_val_i;
      else if (inc_i)  q_q <= (q_q == limit_i) ? LO : bcd_inc(q_q);
   end

   assign q_o    = q_q;
   assign wrap_o = inc_i && (q_q == limit_i);

   assert_wrap_to_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && q_q == limit_i) |=> (q_q == LO));
   assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(q_q));
endmodule

// File: rtl/cal_hour_field.sv
module cal_hour_field (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [7:0] load_val_i,
   input  logic       inc_i,
   output logic [7:0] q_o,
   output logic       day_o
);
   import cal_pkg::*;
   logic [7:0] q_q, nxt;
   logic [7:0] small_inc;
   logic       mode12;

   assign mode12    = q_q[H12_BIT];
   assign small_inc = bcd_inc({3'b000, q_q[4:0]});

   always_comb begin
      nxt = q_q;
      if (mode12) begin
         if (q_q[4:0] == 5'h12)      nxt = {q_q[7:5], 5'h01};
         else if (q_q[4:0] == 5'h11) nxt = {q_q[7:6], ~q_q[PM_BIT], 5'h12};
         else                        nxt = {q_q[7:5], small_inc[4:0]};
      end else begin
         nxt = (q_q == 8'h23) ? 8'h00 : bcd_inc(q_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_q <= 8'h00;
      else if (load_i) q_q <= load_val_i;
      else if (inc_i)  q_q <= nxt;
   end

   assign q_o   = q_q;
   assign day_o = inc_i && (mode12 ? (q_q[PM_BIT] && q_q[4:0] == 5'h11) : (q_q == 8'h23));

   assert_midnight_24_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && q_q == 8'h23) |=> (q_q == 8'h00));
   assert_noon_pm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && q_q == 8'h51) |=> (q_q == 8'h72));
   assert_midnight_12_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && q_q == 8'h71) |=> (q_q == 8'h52));
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned ADDR_W        = 3,
   parameter logic [7:0]  CTRL_RESET    = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o
);
   import cal_pkg::*;

   localparam int unsigned NFIELD = NUM_REGS - 1;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover eight registers");
      end
   endgenerate

   logic [7:0]        ctrl_q;
   logic              wr_time;
   logic [NFIELD-1:0] load_sel;
   logic              sec_tick;
   logic              sec_wrap, min_wrap, day_carry, date_wrap, mon_wrap;
   logic              wday_wrap_unused, year_wrap_unused;
   logic [7:0]        sec_q, min_q, hour_q, wday_q, date_q, mon_q, year_q;
   logic [7:0]        month_end;

   assign wr_time = wr_en_i && (wr_addr_i < ADDR_W'(CTRL_ADDR)) && !ctrl_q[WPROT_BIT];

   generate
      for (genvar k = 0; k < NFIELD; k++) begin : g_sel
         assign load_sel[k] = wr_time && (wr_addr_i == ADDR_W'(k));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_RESET;
      else if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR)) ctrl_q <= wr_data_i;
   end

   cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
      .clk(clk), .rst_n(rst_n), .strobe_i(osc_tick_i),
      .run_i(!ctrl_q[STOP_BIT]), .clear_i(wr_time), .sec_pulse_o(sec_tick));

   cal_bcd_field #(.LO(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .load_i(load_sel[F_SEC]), .load_val_i(wr_data_i & 8'h7F),
      .inc_i(sec_tick), .limit_i(8'h59), .q_o(sec_q), .wrap_o(sec_wrap));

   cal_bcd_field #(.LO(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .load_i(load_sel[F_MIN]), .load_val_i(wr_data_i & 8'h7F),
      .inc_i(sec_wrap), .limit_i(8'h59), .q_o(min_q), .wrap_o(min_wrap));

   cal_hour_field u_hour (
      .clk(clk), .rst_n(rst_n), .load_i(load_sel[F_HOUR]), .load_val_i(wr_data_i & 8'h7F),
      .inc_i(min_wrap), .q_o(hour_q), .day_o(day_carry));

   cal_bcd_field #(.LO(8'h01)) u_wday (
      .clk(clk), .rst_n(rst_n), .load_i(load_sel[F_WDAY]), .load_val_i(wr_data_i & 8'h07),
      .inc_i(day_carry), .limit_i(8'h07), .q_o(wday_q), .wrap_o(wday_wrap_unused));

   assign month_end = last_day(mon_q, year_q);

   cal_bcd_field #(.LO(8'h01)) u_date (
      .clk(clk), .rst_n(rst_n), .load_i(load_sel[F_DATE]), .load_val_i(wr_data_i & 8'h3F),
      .inc_i(day_carry), .limit_i(month_end), .q_o(date_q), .wrap_o(date_wrap));

   cal_bcd_field #(.LO(8'h01)) u_mon (
      .clk(clk), .rst_n(rst_n), .load_i(load_sel[F_MON]), .load_val_i(wr_data_i & 8'h1F),
      .inc_i(date_wrap), .limit_i(8'h12), .q_o(mon_q), .wrap_o(mon_wrap));

   cal_bcd_field #(.LO(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .load_i(load_sel[F_YEAR]), .load_val_i(wr_data_i),
      .inc_i(mon_wrap), .limit_i(8'h99), .q_o(year_q), .wrap_o(year_wrap_unused));

   always_comb begin
      case (rd_addr_i)
         ADDR_W'(F_SEC):     rd_data_o = sec_q;
         ADDR_W'(F_MIN):     rd_data_o = min_q;
         ADDR_W'(F_HOUR):    rd_data_o = hour_q;
         ADDR_W'(F_WDAY):    rd_data_o = wday_q;
         ADDR_W'(F_DATE):    rd_data_o = date_q;
         ADDR_W'(F_MON):     rd_data_o = mon_q;
         ADDR_W'(F_YEAR):    rd_data_o = year_q;
         ADDR_W'(CTRL_ADDR): rd_data_o = ctrl_q;
         default:            rd_data_o = 8'h00;
      endcase
   end

   assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[STOP_BIT] && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));
   assert_wprot_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[WPROT_BIT] && wr_en_i && wr_addr_i == ADDR_W'(F_SEC) && !sec_tick) |=> $stable(sec_q));
   assert_day_moves_wday_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (day_carry && !wr_time && wday_q != 8'h07) |=> (wday_q != $past(wday_q)));
endmodule

// File: tb/bcd_calendar_core_tb.sv
`timescale 1ns/100ps
module bcd_calendar_core_tb;
   localparam int T = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bcd_calendar_core #(.TICKS_PER_SEC(T), .ADDR_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

   function automatic logic [7:0] bcd(input int n);
      return 8'(((n / 10) << 4) | (n % 10));
   endfunction

   function automatic logic [7:0] enc12(input int h);
      int hh = (h % 12 == 0) ? 12 : h % 12;
      return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(hh);
   endfunction

   function automatic int mlen(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic strobe(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); osc_tick = 1'b1;
         @(negedge clk); osc_tick = 1'b0;
      end
   endtask

   task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
      rd_addr = a; #1;
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s addr %0d actual %h expected %h", req, a, rd_data, exp);
      end
   endtask

   task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] wd, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
      wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, wd);
      wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired, actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(3'd7, 8'h80, "R1"); chk(3'd0, 8'h00, "R1"); chk(3'd1, 8'h00, "R1");
      chk(3'd2, 8'h00, "R1"); chk(3'd3, 8'h01, "R1"); chk(3'd4, 8'h01, "R1");
      chk(3'd5, 8'h01, "R1"); chk(3'd6, 8'h00, "R1");
      // R3 stopped after reset
      strobe(3 * T);
      chk(3'd0, 8'h00, "R3");
      wr(3'd7, 8'h00);
      chk(3'd7, 8'h00, "R11");
      // R11 readback with masking
      wr(3'd3, 8'hFF); chk(3'd3, 8'h07, "R11");
      wr(3'd5, 8'hF2); chk(3'd5, 8'h12, "R11");
      wr(3'd0, 8'hC5); chk(3'd0, 8'h45, "R11");
      wr(3'd6, 8'h87); chk(3'd6, 8'h87, "R11");

      // R2 long sweep from midnight, 24-hour format
      set_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      for (int s = 1; s <= 3700; s++) begin
         strobe(T);
         chk(3'd0, bcd(s % 60), "R2");
         chk(3'd1, bcd((s / 60) % 60), "R2");
         chk(3'd2, bcd(s / 3600), "R4");
      end

      // R10 prescaler restart on write
      strobe(2);
      wr(3'd0, 8'h10);
      strobe(T - 1);
      chk(3'd0, 8'h10, "R10");
      strobe(1);
      chk(3'd0, 8'h11, "R10");

      // R3 stop bit halts mid-run
      wr(3'd7, 8'h80);
      strobe(3 * T);
      chk(3'd0, 8'h11, "R3");
      wr(3'd7, 8'h00);

      // R9 write protect
      wr(3'd7, 8'h40);
      wr(3'd0, 8'h33); chk(3'd0, 8'h11, "R9");
      wr(3'd6, 8'h55); chk(3'd6, 8'h00, "R9");
      chk(3'd7, 8'h40, "R9");
      wr(3'd7, 8'h00);
      wr(3'd0, 8'h33); chk(3'd0, 8'h33, "R9");

      // R4 every 24-hour rollover
      for (int h = 0; h < 24; h++) begin
         set_all(bcd(h), 8'h59, 8'h59, 8'h01, 8'h10, 8'h01, 8'h00);
         strobe(T);
         chk(3'd2, bcd((h + 1) % 24), "R4");
         chk(3'd1, 8'h00, "R4");
         chk(3'd4, (h == 23) ? 8'h11 : 8'h10, "R4");
      end

      // R5 every 12-hour rollover
      for (int h = 0; h < 24; h++) begin
         set_all(enc12(h), 8'h59, 8'h59, 8'h01, 8'h10, 8'h01, 8'h00);
         strobe(T);
         chk(3'd2, enc12((h + 1) % 24), "R5");
         chk(3'd4, (h == 23) ? 8'h11 : 8'h10, "R5");
      end

      // R6 weekday wrap
      for (int wd = 1; wd <= 7; wd++) begin
         set_all(8'h23, 8'h59, 8'h59, bcd(wd), 8'h05, 8'h03, 8'h10);
         strobe(T);
         chk(3'd3, bcd(wd % 7 + 1), "R6");
      end

      // R7 month ends in a common year
      for (int m = 1; m <= 12; m++) begin
         set_all(8'h23, 8'h59, 8'h59, 8'h01, bcd(mlen(m, 23) - 1), bcd(m), 8'h23);
         strobe(T);
         chk(3'd4, bcd(mlen(m, 23)), "R7");
         wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
         strobe(T);
         chk(3'd4, 8'h01, "R7");
         chk(3'd5, bcd(m % 12 + 1), "R8");
      end

      // R7 leap sweep over the century
      for (int y = 0; y < 100; y++) begin
         set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, bcd(y));
         strobe(T);
         chk(3'd4, (y % 4 == 0) ? 8'h29 : 8'h01, "R7");
         chk(3'd5, (y % 4 == 0) ? 8'h02 : 8'h03, "R7");
      end

      // R8 year advance and century wrap
      for (int y = 0; y < 100; y++) begin
         set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, bcd(y));
         strobe(T);
         chk(3'd6, bcd((y + 1) % 100), "R8");
         chk(3'd5, 8'h01, "R8");
         chk(3'd4, 8'h01, "R8");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule